// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This unit sits beside the ALU of a 32-bit processor and carries out integer multiplication and division over a series of clock cycles instead of in one combinational pass. The processor presents two operand words, selects multiply or divide and signed or unsigned operation, and pulses `start`. The unit then raises `busy` for the length of the operation. The complement of `busy` can drive the program-counter write enable directly, so the core stalls until the results are ready.

Multiplication uses radix-4 Booth recoding, so each iteration retires two multiplier bits. Division is restoring and works on magnitudes. Signed operands are converted to magnitudes before the divide loop, and the signs of the quotient and the remainder are corrected afterwards. Every step that needs an adder goes through one shared add/subtract stage: the Booth accumulation, the trial subtraction, the operand magnitude steps and the sign corrections. The multiply operator is not used anywhere. A zero divisor is outside the operating range and produces no defined result.

Top module: `mdu_iter`

## Requirements
- R1: After reset `busy`, `res_lo` and `res_hi` are 0. A `start` sampled while idle makes `busy` read 1 in the following cycle.
- R2: With `op_div`=0, `res_hi:res_lo` holds the full 2W-bit product. The operands are two's complement when `is_signed`=1 and unsigned when `is_signed`=0.
- R3: For the same operands, the low product half in `res_lo` is identical whether `is_signed` is 0 or 1.
- R4: With `op_div`=1 and `is_signed`=0, `res_lo` holds the unsigned quotient `opa`/`opb` and `res_hi` holds the remainder.
- R5: With `op_div`=1 and `is_signed`=1, the quotient is truncated toward zero and the remainder takes the sign of the dividend. The most negative value divided by -1 gives the most negative value as quotient and 0 as remainder.
- R6: `busy` stays high for exactly W/2 cycles for a signed multiply, W/2+1 cycles for an unsigned multiply, and W+4 cycles for a divide.
- R7: A `start` asserted while `busy` is high is ignored. It neither changes the running operation nor queues another one.
- R8: While `busy` is low, `res_lo` and `res_hi` hold their values whatever the operand and select inputs do, until the next operation completes.
- R9: Extreme operands give exact results: the most negative value squared (signed), all-ones squared (unsigned), and a dividend smaller than the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when sampled while idle |
| op_div | input | 1 | 0 selects multiply, 1 selects divide |
| is_signed | input | 1 | 1 treats the operands as two's complement |
| opa | input | W | Multiplicand or dividend |
| opb | input | W | Multiplier or divisor |
| busy | output | 1 | High while an operation runs |
| res_lo | output | W | Low product half or quotient |
| res_hi | output | W | High product half or remainder |

## Verification
The bench targets the operands where sign handling breaks.

A multiplier with its top bit set in unsigned mode exposes a missing final Booth digit, which shows up as a high half short by the multiplicand. Squaring the most negative value overflows an accumulator that is too narrow.

On the divide side, negative dividends and negative divisors catch a remainder that takes the wrong sign or a quotient that rounds toward minus infinity. Dividing the most negative value by -1 checks that the magnitude conversion does not lose the top bit.

Latency is counted on every operation, because an off-by-one iteration count corrupts results only for some operands. A second `start` during a run, and operand changes after completion, would show up as altered results if they leaked through.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_MULX,
    ST_ABSA,
    ST_ABSB,
    ST_DIV,
    ST_FIXQ,
    ST_FIXR
  } mdu_state_e;
endpackage

// File: rtl/mdu_addsub.sv
module mdu_addsub #(
  parameter int AW = 35
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic          sub,
  output logic [AW-1:0] sum
);
  // single carry chain; subtraction by inverting b and injecting carry
  assign sum = a + (b ^ {AW{sub}}) + {{(AW-1){1'b0}}, sub};
endmodule

// File: rtl/mdu_booth_dec.sv
module mdu_booth_dec (
  input  logic [2:0] grp,
  output logic       zero,
  output logic       dbl,
  output logic       neg
);
  always_comb begin
    zero = 1'b0;
    dbl  = 1'b0;
    neg  = 1'b0;
    case (grp)
      3'b000, 3'b111: zero = 1'b1;
      3'b001, 3'b010: ;
      3'b011:         dbl = 1'b1;
      3'b100:         begin dbl = 1'b1; neg = 1'b1; end
      default:        neg = 1'b1;
    endcase
  end
endmodule

// File: rtl/mdu_iter.sv
module mdu_iter
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_div,
  input  logic         is_signed,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi
);
  localparam int AW     = W + 3;
  localparam int CW     = $clog2(W);
  localparam int MSTEPS = W / 2;
  localparam int BCW    = $clog2(W + 8) + 1;

  mdu_state_e    st;
  logic [AW-1:0] hreg, mreg;
  logic [W-1:0]  lreg;
  logic          qbit, sgn, neg_q, neg_r;
  logic [CW-1:0] cnt;

  logic [AW-1:0]   add_a, add_b, add_s;
  logic            add_sub;
  logic [2:0]      grp;
  logic            b_zero, b_dbl, b_neg;
  logic [AW+W-1:0] shft;

  assign grp = (st == ST_MULX) ? {2'b00, qbit} : {lreg[1:0], qbit};

  mdu_booth_dec u_dec (
    .grp  (grp),
    .zero (b_zero),
    .dbl  (b_dbl),
    .neg  (b_neg)
  );

  mdu_addsub #(.AW(AW)) u_add (
    .a   (add_a),
    .b   (add_b),
    .sub (add_sub),
    .sum (add_s)
  );

  // operand steering into the shared adder
  always_comb begin
    add_a   = '0;
    add_b   = '0;
    add_sub = 1'b0;
    case (st)
      ST_MUL, ST_MULX: begin
        add_a   = hreg;
        add_b   = b_zero ? '0 : (b_dbl ? {mreg[AW-2:0], 1'b0} : mreg);
        add_sub = b_neg;
      end
      ST_ABSA: begin
        add_b   = AW'(lreg);
        add_sub = sgn & lreg[W-1];
      end
      ST_ABSB: begin
        add_b   = AW'(mreg[W-1:0]);
        add_sub = sgn & mreg[W-1];
      end
      ST_DIV: begin
        add_a   = AW'({hreg[W-1:0], lreg[W-1]});
        add_b   = mreg;
        add_sub = 1'b1;
      end
      ST_FIXQ: begin
        add_b   = AW'(lreg);
        add_sub = neg_q;
      end
      ST_FIXR: begin
        add_b   = hreg;
        add_sub = neg_r;
      end
      default: ;
    endcase
  end

  // arithmetic shift by two of {sum, multiplier}
  assign shft = {{2{add_s[AW-1]}}, add_s, lreg[W-1:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      hreg   <= '0;
      mreg   <= '0;
      lreg   <= '0;
      qbit   <= 1'b0;
      sgn    <= 1'b0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      cnt    <= '0;
      res_lo <= '0;
      res_hi <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          sgn  <= is_signed;
          cnt  <= '0;
          hreg <= '0;
          qbit <= 1'b0;
          if (!op_div) begin
            mreg <= {{3{is_signed & opa[W-1]}}, opa};
            lreg <= opb;
            st   <= ST_MUL;
          end else begin
            mreg  <= {3'b000, opb};
            lreg  <= opa;
            neg_q <= is_signed & (opa[W-1] ^ opb[W-1]);
            neg_r <= is_signed & opa[W-1];
            st    <= ST_ABSA;
          end
        end
        ST_MUL: begin
          {hreg, lreg} <= shft;
          qbit <= lreg[1];
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(MSTEPS - 1)) begin
            if (sgn) begin
              res_hi <= shft[2*W-1:W];
              res_lo <= shft[W-1:0];
              st     <= ST_IDLE;
            end else begin
              st <= ST_MULX;
            end
          end
        end
        ST_MULX: begin
          res_hi <= add_s[W-1:0];
          res_lo <= lreg;
          st     <= ST_IDLE;
        end
        ST_ABSA: begin
          lreg <= add_s[W-1:0];
          st   <= ST_ABSB;
        end
        ST_ABSB: begin
          mreg <= {3'b000, add_s[W-1:0]};
          st   <= ST_DIV;
        end
        ST_DIV: begin
          hreg <= add_s[AW-1] ? add_a : add_s;
          lreg <= {lreg[W-2:0], ~add_s[AW-1]};
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) st <= ST_FIXQ;
        end
        ST_FIXQ: begin
          lreg <= add_s[W-1:0];
          st   <= ST_FIXR;
        end
        ST_FIXR: begin
          res_lo <= lreg;
          res_hi <= add_s[W-1:0];
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);

  // busy-length monitor for the latency bound
  logic [BCW-1:0] bsy_cnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) bsy_cnt <= '0;
    else              bsy_cnt <= bsy_cnt + 1'b1;
  end

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy); // R1

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(res_lo) && $stable(res_hi))); // R8

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bsy_cnt < BCW'(W + 4))); // R6

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DIV) |-> (hreg[W-1:0] < mreg[W-1:0])); // R4

  AST_MUL_STEPS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MUL) |-> (cnt < CW'(MSTEPS))); // R6

endmodule

// File: tb/mdu_iter_tb.sv
`timescale 1ns/1ps
module mdu_iter_tb_top;
  localparam int W  = 32;
  localparam int NV = 14;

  logic         clk = 1'b0;
  logic         rst;
  logic         start, op_div, is_signed;
  logic [W-1:0] opa, opb;
  logic         busy;
  logic [W-1:0] res_lo, res_hi;

  int nchk  = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  mdu_iter #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op_div(op_div), .is_signed(is_signed),
    .opa(opa), .opb(opb), .busy(busy), .res_lo(res_lo), .res_hi(res_hi)
  );

  // {op_div, is_signed, opa, opb}
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 1'b1, 32'h0000_0007, 32'hFFFF_FFFD},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000},
    {1'b0, 1'b0, 32'h8000_0000, 32'h0000_0003},
    {1'b0, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0},
    {1'b0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0},
    {1'b0, 1'b1, 32'h0000_0000, 32'h8000_0000},
    {1'b1, 1'b0, 32'h0000_0064, 32'h0000_0007},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001},
    {1'b1, 1'b1, 32'hFFFF_FF9C, 32'h0000_0007},
    {1'b1, 1'b1, 32'h0000_0064, 32'hFFFF_FFF9},
    {1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF},
    {1'b1, 1'b0, 32'h0000_0005, 32'h0000_0009},
    {1'b1, 1'b1, 32'hFFFF_FFF9, 32'hFFFF_FFFE}
  };

  function automatic logic [63:0] model(logic d, logic s, logic [31:0] a, logic [31:0] b);
    longint sa, sb, q, r;
    sa = s ? longint'($signed(a)) : longint'({32'b0, a});
    sb = s ? longint'($signed(b)) : longint'({32'b0, b});
    if (!d) return 64'(sa * sb);
    q = sa / sb;
    r = sa % sb;
    return {r[31:0], q[31:0]};
  endfunction

  function automatic int exp_lat(logic d, logic s);
    if (d) return W + 4;
    return s ? W / 2 : W / 2 + 1;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic d, logic s, logic [31:0] a, logic [31:0] b, output int lat);
    @(negedge clk);
    op_div = d; is_signed = s; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 busy after start", 64'(busy), 64'd1);
    lat = 0;
    while (busy) begin
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int lat;
    logic [63:0] keep;
    logic [31:0] lo_s;
    rst = 1'b1; start = 1'b0; op_div = 1'b0; is_signed = 1'b0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset busy", 64'(busy), 64'd0);
    check("R1 reset results", {res_hi, res_lo}, 64'd0);

    // table walk: R2, R4, R5, R6, R9
    for (int i = 0; i < NV; i++) begin
      logic [65:0] v;
      v = VEC[i];
      run_op(v[65], v[64], v[63:32], v[31:0], lat);
      check(v[65] ? (v[64] ? "R5 signed div" : "R4 unsigned div") : "R2 multiply",
            {res_hi, res_lo}, model(v[65], v[64], v[63:32], v[31:0]));
      check("R6 latency", 64'(lat), 64'(exp_lat(v[65], v[64])));
    end

    // R3: low half independent of signedness
    run_op(1'b0, 1'b1, 32'hDEAD_BEEF, 32'hF00D_CAFE, lat);
    lo_s = res_lo;
    run_op(1'b0, 1'b0, 32'hDEAD_BEEF, 32'hF00D_CAFE, lat);
    check("R3 low half equal", 64'(res_lo), 64'(lo_s));

    // R9: corner operands
    run_op(1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, lat);
    check("R9 min squared", {res_hi, res_lo}, 64'h4000_0000_0000_0000);
    run_op(1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, lat);
    check("R9 ones squared", {res_hi, res_lo}, 64'hFFFF_FFFE_0000_0001);
    run_op(1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, lat);
    check("R5 min div minus one", {res_hi, res_lo}, 64'h0000_0000_8000_0000);

    // R7: second start during a run is ignored
    @(negedge clk);
    op_div = 1'b0; is_signed = 1'b1; opa = 32'h0000_0007; opb = 32'hFFFF_FFFD; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    op_div = 1'b1; is_signed = 1'b0; opa = 32'h0000_0064; opb = 32'h0000_0003; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 4;
    while (busy) begin
      lat++;
      @(negedge clk);
    end
    check("R7 result of first op", {res_hi, res_lo}, 64'hFFFF_FFFF_FFFF_FFEB);
    check("R7 latency unchanged", 64'(lat), 64'(W / 2));
    repeat (2) @(negedge clk);
    check("R7 nothing queued", 64'(busy), 64'd0);

    // R8: results hold while idle
    keep = {res_hi, res_lo};
    op_div = 1'b1; is_signed = 1'b1; opa = 32'h1111_1111; opb = 32'h0000_0002;
    repeat (10) @(negedge clk);
    check("R8 results held", {res_hi, res_lo}, keep);
    check("R8 stays idle", 64'(busy), 64'd0);

    summary();
    $finish;
  end
endmodule